// File: doc/BRIEF.md
# Machine Counter and Identification CSR Slice

This block is a small slice of the control-and-status register file of a 64-bit RISC-V hart. It holds the free-running cycle counter, the retired-instruction counter, the counter-inhibit control and the constant implementation identification registers. It also decides whether a CSR access is legal. Legality depends on the 12-bit CSR address and on the privilege level the hart is running at.

The pipeline presents one CSR address per cycle, together with a write strobe and write data. It receives read data and the two legality flags combinationally in the same cycle, and uses the flags to decide whether to raise an exception. A write changes state at the next clock edge, and only when it is legal. A separate one-cycle pulse marks each retired instruction. Machine CSRs outside this slice are decoded for legality only and read as zero here.

Top module: `mctr_csr_unit`

## Requirements
- R1: The identification CSRs at 0xF11, 0xF12, 0xF13 and 0xF14 read as zero and are read-legal in machine mode. A write to any of them is flagged illegal at every privilege.
- R2: Privilege is encoded U=0, S=1, M=3. The machine CSR set is 0x300–0x306, 0x320, 0x340–0x344, 0x3A0, 0x3B0, 0x744, 0x7A0–0x7A2, 0x7A5, 0xB02 and 0xF11–0xF14. A machine CSR is legal to read only in M. It is legal to write only in M and only when it is not an identification CSR. Any address outside the machine set and the user counter views is illegal for both read and write.
- R3: The counter-inhibit CSR at 0x320 keeps only bit 2, the instruction-retire inhibit. All other bits read back as zero.
- R4: The retired-instruction counter is readable and writable in M at 0xB02. The same storage is read through the user view at 0xC02.
- R5: On each cycle with the retire pulse high, the retired-instruction counter adds one, provided bit 2 of 0x320 is clear. It wraps from all ones to zero. With the pulse low or the bit set, it holds.
- R6: A legal write to 0xB02 loads the written value with no increment, even when the retire pulse is high in the same cycle. A read on the next cycle returns exactly that value.
- R7: The user counter views at 0xC00 (cycle), 0xC01 (time) and 0xC02 (instret) are read-legal at every privilege. A write to them is illegal and changes nothing.
- R8: The cycle counter adds one on every clock after reset. The time view at 0xC01 returns the same value as 0xC00.
- R9: After reset all counters and the inhibit bit are zero. Read data is zero whenever the read is illegal, or when the address is a legal CSR not held in this slice.
- R10: A write strobe on an illegal access leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| priv | input | 2 | Current privilege (U=0, S=1, M=3) |
| retire | input | 1 | One pulse per retired instruction |
| csr_addr | input | 12 | CSR address of the current access |
| csr_we | input | 1 | Write strobe for the current access |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data, zero when the read is illegal |
| rd_legal | output | 1 | Read of csr_addr is legal at priv |
| wr_legal | output | 1 | Write of csr_addr is legal at priv |

## Verification
The embedded assertions assume a known, two-valued privilege and address in every cycle after reset. They also assume the write strobe is qualified by the same cycle's address, so a legal minstret write and a retire pulse may coincide. They also assume reset is held for at least one clock before use. The stimulus drives privilege only from the three defined encodings. It changes inputs on the falling clock edge. It mixes a pool of boundary addresses, such as the ends of each machine range, neighbours just outside them and the user views, with fully random addresses. Write strobes and retire pulses land in arbitrary combinations, including the same cycle.

// File: rtl/mctr_csr_pkg.sv
// Package: shared constants and types for the machine counter CSR slice.
// Assumes a 12-bit CSR address space and two-bit privilege codes.
package mctr_csr_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    localparam int ADDR_W = 12;
    localparam int NUM_ID = 4;
    localparam int IR_BIT = 2;

    localparam logic [ADDR_W-1:0] A_INHIBIT  = 12'h320;
    localparam logic [ADDR_W-1:0] A_MINSTRET = 12'hB02;
    localparam logic [ADDR_W-1:0] A_UCYCLE   = 12'hC00;
    localparam logic [ADDR_W-1:0] A_UTIME    = 12'hC01;
    localparam logic [ADDR_W-1:0] A_UINSTRET = 12'hC02;
    localparam logic [ADDR_W-1:0] A_ID_BASE  = 12'hF11;

    typedef struct packed {
        logic is_machine;
        logic is_id;
        logic is_alias;
        logic is_inhibit;
        logic is_minstret;
        logic is_cycle_view;
        logic is_instret_view;
    } csr_class_t;

endpackage

// File: rtl/mctr_addr_class.sv
// Module: classifies a CSR address into the groups the slice cares about.
// Assumes: purely combinational; the ID registers are consecutive from A_ID_BASE.
module mctr_addr_class
    import mctr_csr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output csr_class_t        cls
);

    logic [NUM_ID-1:0] id_hit;
    logic              other_m;

    // One comparator per identification register.
    for (genvar gi = 0; gi < NUM_ID; gi++) begin : g_id
        assign id_hit[gi] = (addr == A_ID_BASE + ADDR_W'(gi));
    end

    // Machine CSRs that are legality-decoded but not stored in this slice.
    always_comb begin
        other_m = addr inside {[12'h300:12'h306], [12'h340:12'h344], 12'h3A0,
                               12'h3B0, 12'h744, [12'h7A0:12'h7A2], 12'h7A5};
    end

    // Assemble the classification record.
    always_comb begin
        cls.is_id           = |id_hit;
        cls.is_inhibit      = (addr == A_INHIBIT);
        cls.is_minstret     = (addr == A_MINSTRET);
        cls.is_alias        = addr inside {[A_UCYCLE:A_UINSTRET]};
        cls.is_cycle_view   = (addr == A_UCYCLE) || (addr == A_UTIME);
        cls.is_instret_view = (addr == A_UINSTRET) || (addr == A_MINSTRET);
        cls.is_machine      = other_m | cls.is_id | cls.is_inhibit | cls.is_minstret;
    end

endmodule

// File: rtl/mctr_access_check.sv
// Module: read/write legality decision from address class and privilege.
// Assumes: user counter views need no enable control; ID registers are read-only.
module mctr_access_check
    import mctr_csr_pkg::*;
(
    input  logic       is_machine,
    input  logic       is_id,
    input  logic       is_alias,
    input  logic [1:0] priv,
    output logic       rd_ok,
    output logic       wr_ok
);

    logic in_m;

    // Decide legality; user views are read-only at any privilege.
    always_comb begin
        in_m  = (priv == 2'(PRIV_M));
        rd_ok = (is_machine && in_m) || is_alias;
        wr_ok = is_machine && in_m && !is_id;
    end

endmodule

// File: rtl/mctr_counter.sv
// Module: W-bit counter with synchronous load taking priority over increment.
// Assumes: wraps to zero on overflow; active-low synchronous reset to zero.
module mctr_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q
);

    // Load beats increment so a written value is seen unmodified.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= load_val;
        else if (inc)   q <= q + W'(1);
    end

endmodule

// File: rtl/mctr_csr_unit.sv
// Module: top of the machine counter/ID CSR slice.
// Holds cycle and retired-instruction counters plus the retire-inhibit bit,
// and reports read/write legality for any 12-bit CSR address.
// Assumes: write strobe is qualified by the same-cycle address; reads are combinational.
module mctr_csr_unit
    import mctr_csr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        priv,
    input  logic              retire,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              csr_we,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              rd_legal,
    output logic              wr_legal
);

    csr_class_t      cls;
    logic            wr_fire;
    logic            instret_wr;
    logic            ir_q;
    logic [XLEN-1:0] cycle_q;
    logic [XLEN-1:0] instret_q;
    logic [XLEN-1:0] rd_raw;
    logic            chk_live;

    mctr_addr_class u_class (
        .addr (csr_addr),
        .cls  (cls)
    );

    mctr_access_check u_access (
        .is_machine (cls.is_machine),
        .is_id      (cls.is_id),
        .is_alias   (cls.is_alias),
        .priv       (priv),
        .rd_ok      (rd_legal),
        .wr_ok      (wr_legal)
    );

    // Qualify the write strobe with legality.
    always_comb begin
        wr_fire    = csr_we && wr_legal;
        instret_wr = wr_fire && cls.is_minstret;
    end

    mctr_counter #(.W(XLEN)) u_cycle (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (1'b1),
        .load     (1'b0),
        .load_val ('0),
        .q        (cycle_q)
    );

    mctr_counter #(.W(XLEN)) u_instret (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (retire && !ir_q),
        .load     (instret_wr),
        .load_val (csr_wdata),
        .q        (instret_q)
    );

    // Retire-inhibit bit: the only implemented bit of the inhibit CSR.
    always_ff @(posedge clk) begin
        if (!rst_n)                        ir_q <= 1'b0;
        else if (wr_fire && cls.is_inhibit) ir_q <= csr_wdata[IR_BIT];
    end

    // Read multiplexer; unheld CSRs return zero.
    always_comb begin
        rd_raw = '0;
        if (cls.is_cycle_view)        rd_raw = cycle_q;
        else if (cls.is_instret_view) rd_raw = instret_q;
        else if (cls.is_inhibit)      rd_raw[IR_BIT] = ir_q;
        csr_rdata = rd_legal ? rd_raw : '0;
    end

    // Marks cycles whose previous edge was out of reset, for history checks.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_live <= 1'b0;
        else        chk_live <= 1'b1;
    end

    AST_ID_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        cls.is_id |-> !wr_legal); // R1

    AST_NONM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (priv != 2'(PRIV_M)) |-> !wr_legal); // R2

    AST_INSTRET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_live && $past(!retire && !instret_wr) |-> $stable(instret_q)); // R5

    AST_INHIBIT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_live && $past(ir_q && !instret_wr) |-> $stable(instret_q)); // R5

    AST_MINSTRET_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        chk_live && $past(instret_wr) |-> instret_q == $past(csr_wdata)); // R6

    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        chk_live |-> cycle_q == $past(cycle_q) + XLEN'(1)); // R8

    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_legal |-> csr_rdata == '0); // R9

endmodule

// File: tb/sim_mctr_csr_unit.sv
// Bench: seeded random plus directed accesses against a bench-side model.
module sim_mctr_csr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  priv = 2'd3;
    logic        retire = 1'b0;
    logic [11:0] csr_addr = '0;
    logic        csr_we = 1'b0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        rd_legal;
    logic        wr_legal;

    int checks = 0;
    int failures = 0;
    logic [63:0] m_cycle = '0;
    logic [63:0] m_instret = '0;
    logic        m_ir = 1'b0;

    always #5 clk = ~clk;

    mctr_csr_unit u0 (
        .clk(clk), .rst_n(rst_n), .priv(priv), .retire(retire),
        .csr_addr(csr_addr), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .rd_legal(rd_legal), .wr_legal(wr_legal)
    );

    function automatic bit f_machine(input logic [11:0] a);
        return (a >= 12'h300 && a <= 12'h306) || a == 12'h320 ||
               (a >= 12'h340 && a <= 12'h344) || a == 12'h3A0 || a == 12'h3B0 ||
               a == 12'h744 || (a >= 12'h7A0 && a <= 12'h7A2) || a == 12'h7A5 ||
               a == 12'hB02 || (a >= 12'hF11 && a <= 12'hF14);
    endfunction

    function automatic bit f_user_view(input logic [11:0] a);
        return a >= 12'hC00 && a <= 12'hC02;
    endfunction

    function automatic bit f_rd_ok(input logic [11:0] a, input logic [1:0] p);
        return (f_machine(a) && p == 2'd3) || f_user_view(a);
    endfunction

    function automatic bit f_wr_ok(input logic [11:0] a, input logic [1:0] p);
        return f_machine(a) && p == 2'd3 && !(a >= 12'hF11 && a <= 12'hF14);
    endfunction

    function automatic logic [63:0] f_value(input logic [11:0] a);
        if (a == 12'hC00 || a == 12'hC01) return m_cycle;
        if (a == 12'hC02 || a == 12'hB02) return m_instret;
        if (a == 12'h320) return {61'd0, m_ir, 2'd0};
        return 64'd0;
    endfunction

    function automatic logic [11:0] f_pick(input int n);
        case (n)
            0: return 12'h300;  1: return 12'h306;  2: return 12'h307;
            3: return 12'h320;  4: return 12'h344;  5: return 12'h3A0;
            6: return 12'h3B0;  7: return 12'h744;  8: return 12'h7A2;
            9: return 12'h7A3;  10: return 12'h7A5; 11: return 12'hB02;
            12: return 12'hB00; 13: return 12'hC00; 14: return 12'hC01;
            15: return 12'hC02; 16: return 12'hC03; 17: return 12'hF11;
            18: return 12'hF14; 19: return 12'hF15; 20: return 12'hB02;
            default: return 12'($urandom);
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One access: drive, check combinational outputs, advance model and clock.
    task automatic step(input logic [1:0] p, input logic [11:0] a, input bit we,
                        input logic [63:0] wd, input bit ret, input string req);
        bit er, ew;
        logic [63:0] ed;
        priv = p; csr_addr = a; csr_we = we; csr_wdata = wd; retire = ret;
        #1;
        er = f_rd_ok(a, p);
        ew = f_wr_ok(a, p);
        ed = er ? f_value(a) : 64'd0;
        check(rd_legal == er, req, "rd_legal", 64'(rd_legal), 64'(er));
        check(wr_legal == ew, req, "wr_legal", 64'(wr_legal), 64'(ew));
        check(csr_rdata == ed, req, "rdata", csr_rdata, ed);
        if (we && ew && a == 12'hB02)  m_instret = wd;
        else if (ret && !m_ir)         m_instret = m_instret + 64'd1;
        if (we && ew && a == 12'h320)  m_ir = wd[2];
        m_cycle = m_cycle + 64'd1;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        #2000000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check(csr_rdata == 64'd0 && rd_legal == 1'b0, "R9", "reset idle read", csr_rdata, 64'd0);
        rst_n = 1'b1;
        step(2'd3, 12'hC00, 0, 0, 0, "R9");
        step(2'd3, 12'hB02, 0, 0, 0, "R9");
        step(2'd3, 12'h320, 0, 0, 0, "R9");
        // R1: ID registers read zero, writes illegal
        for (int i = 0; i < 4; i++) step(2'd3, 12'hF11 + 12'(i), 1, '1, 1, "R1");
        step(2'd0, 12'hF12, 1, '1, 0, "R1");
        // R6: write with coincident retire loads exactly
        step(2'd3, 12'hB02, 1, 64'd100, 1, "R6");
        check(csr_rdata == 64'd100, "R6", "minstret after write", csr_rdata, 64'd100);
        step(2'd3, 12'hC02, 0, 0, 1, "R4");
        step(2'd3, 12'hB02, 0, 0, 0, "R5");
        check(csr_rdata == 64'd101, "R5", "one retire", csr_rdata, 64'd101);
        // R3: only bit 2 kept; inhibit freezes counting
        step(2'd3, 12'h320, 1, '1, 0, "R3");
        step(2'd3, 12'h320, 0, 0, 1, "R3");
        check(csr_rdata == 64'd4, "R3", "inhibit readback", csr_rdata, 64'd4);
        step(2'd3, 12'hB02, 0, 0, 1, "R5");
        step(2'd3, 12'h320, 1, 64'd0, 0, "R3");
        // R2: non-M access to machine CSRs
        step(2'd1, 12'h300, 1, 64'd7, 0, "R2");
        step(2'd0, 12'h7A5, 0, 0, 0, "R2");
        step(2'd3, 12'h7A3, 1, 64'd7, 0, "R2");
        // R10: illegal write to minstret leaves state
        step(2'd1, 12'hB02, 1, 64'd55, 0, "R10");
        step(2'd3, 12'hB02, 0, 0, 0, "R10");
        // R7: user views read anywhere, writes ignored
        step(2'd3, 12'hC02, 1, 64'd9, 0, "R7");
        step(2'd0, 12'hC02, 0, 0, 0, "R7");
        step(2'd1, 12'hC00, 1, 64'd9, 0, "R7");
        // R8: cycle and time views agree
        step(2'd0, 12'hC01, 0, 0, 0, "R8");
        step(2'd3, 12'hC00, 0, 0, 0, "R8");
        // R5: wrap from all ones
        step(2'd3, 12'hB02, 1, '1, 0, "R5");
        step(2'd3, 12'hB02, 0, 0, 1, "R5");
        step(2'd3, 12'hB02, 0, 0, 0, "R5");
        check(csr_rdata == 64'd0, "R5", "wrap to zero", csr_rdata, 64'd0);
        // Random mix over boundary pool and random addresses
        for (int i = 0; i < 1500; i++) begin
            int pk;
            logic [1:0] p;
            pk = int'($urandom % 3);
            p = (pk == 0) ? 2'd0 : (pk == 1) ? 2'd1 : 2'd3;
            step(p, f_pick(int'($urandom % 24)), ($urandom % 3) == 0,
                 {$urandom, $urandom}, ($urandom % 2) == 1, "R2/R5/R9");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule